// File: doc/BRIEF.md
# JTAG Scan Chain Selector

This block sits behind a JTAG TAP controller. It holds the number of the scan chain that data-register scans act on. It also steers the serial stream between TDI, the selected chain and TDO. A dedicated select instruction loads a new five-bit chain number. The block captures a fixed marker into its own five-bit select register, shifts the new number in LSB first and commits it in update-DR. Every other instruction leaves the number alone and works on the chain that is already selected.

The number picks one of three routes. Six internal chains each return their serial data on their own input pin. Chain 3 and every number from 16 to 31 go to one shared port for an external chain. The remaining numbers have no chain behind them, so a one-bit bypass stage keeps the scan path defined. The TAP state machine, the instruction decoder and the chain contents sit outside this block. It sees the TAP state only through three state strobes and one decoded instruction flag.

Top module: `scan_chain_router`

## Requirements
- R1: `active_chain` always shows the held five-bit chain number.
- R2: On a rising TCK edge with `update_dr` and `sel_instr` both high, the held chain number takes the value of the select shift register.
- R3: The held chain number keeps its value on every rising TCK edge where `update_dr` and `sel_instr` are not both high. This includes update-DR under another instruction and capture or shift under any instruction.
- R4: While `trst_n` is low, the held chain number is 3 and `tdo` is 0.
- R5: When the held number is 3 or 16 to 31 and `sel_instr` is low, `ext_sout` follows `tdi` and `tdo` carries `ext_ret`. With any other number, or while `sel_instr` is high, `ext_sout` is 0.
- R6: With `sel_instr` low, the internal chains return on `int_ret`, and `tdo` carries the bit of the held chain. The bit order is: bit 0 is chain 0, bit 1 is chain 1, bit 2 is chain 2, bit 3 is chain 4, bit 4 is chain 5, bit 5 is chain 15.
- R7: With `sel_instr` low and a reserved number (6 to 14) held, a one-bit bypass stage sits between `tdi` and `tdo`. It loads 0 on a rising edge in capture-DR and loads `tdi` on a rising edge in shift-DR.
- R8: With `sel_instr` high, capture-DR loads 5'b10000 into the select shift register. Shift-DR moves `tdi` into bit 4 and moves the other bits one place toward bit 0. `tdo` carries bit 0.
- R9: `tdo` changes only on a falling TCK edge. There it takes the value of the routed source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low reset |
| capture_dr | input | 1 | TAP is in capture-DR |
| shift_dr | input | 1 | TAP is in shift-DR |
| update_dr | input | 1 | TAP is in update-DR |
| sel_instr | input | 1 | Current instruction is the chain-select instruction |
| tdi | input | 1 | Serial test data in |
| int_ret | input | 6 | Serial return of internal chains 0, 1, 2, 4, 5, 15 (bit 0 upward) |
| ext_ret | input | 1 | Serial return from the external chain port |
| active_chain | output | 5 | Held chain number |
| ext_sout | output | 1 | Serial data toward the external chain |
| tdo | output | 1 | Test data out, retimed on the falling edge |

## Verification
Every chain number from 0 to 31 is selected through a real capture, shift and update sequence. The bits shifted out are compared against the capture marker, which separates a correct select register from one that is misaligned or shifts the wrong way. Each selection is then probed with several random values on `int_ret`, `ext_ret` and `tdi`. A wrong bit position, a chain sent down the wrong route, or an `ext_sout` leaking `tdi` all show up as a `tdo` or `ext_sout` mismatch. Directed cases cover the remaining rules:
- update-DR, capture and shift under other instructions, to show the number is held;
- a reset in the middle of the run;
- the bypass stage capturing and shifting on reserved numbers;
- `ext_ret` changing inside the clock's low phase, to show that `tdo` waits for the falling edge.

A random run over chain numbers repeats these checks with new data.

// File: rtl/scr_pkg.sv
package scr_pkg;

  localparam int unsigned CHAIN_W = 5;
  localparam int unsigned N_INT   = 6;

  // chain number after reset, also the dedicated external boundary chain
  localparam logic [CHAIN_W-1:0] RESET_CHAIN = 5'd3;
  localparam logic [CHAIN_W-1:0] EXT_CHAIN   = 5'd3;
  // numbers at or above this one are unassigned and go to the external port
  localparam logic [CHAIN_W-1:0] FIRST_FREE  = 5'd16;
  // constant loaded into the select shift register on capture-DR
  localparam logic [CHAIN_W-1:0] SEL_MARKER  = 5'b10000;

  // internal chain number carried by each bit of the return vector
  localparam logic [CHAIN_W-1:0] INT_ID [N_INT] =
    '{5'd0, 5'd1, 5'd2, 5'd4, 5'd5, 5'd15};

  typedef enum logic [1:0] {
    ROUTE_INT = 2'd0,
    ROUTE_EXT = 2'd1,
    ROUTE_BYP = 2'd2
  } route_e;

endpackage

// File: rtl/scr_select_reg.sv
module scr_select_reg
  import scr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_en,
  input  logic               shf_en,
  input  logic               upd_en,
  input  logic               ser_in,
  output logic [CHAIN_W-1:0] sreg_o,
  output logic [CHAIN_W-1:0] active_o
);

  logic [CHAIN_W-1:0] sreg_q;
  logic [CHAIN_W-1:0] sreg_nxt;
  logic [CHAIN_W-1:0] act_q;
  logic [CHAIN_W-1:0] act_nxt;

  always_comb begin
    sreg_nxt = sreg_q;
    if (cap_en) begin
      sreg_nxt = SEL_MARKER;
    end else if (shf_en) begin
      sreg_nxt = {ser_in, sreg_q[CHAIN_W-1:1]};
    end
  end

  always_comb begin
    act_nxt = act_q;
    if (upd_en) begin
      act_nxt = sreg_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      act_q  <= RESET_CHAIN;
    end else begin
      sreg_q <= sreg_nxt;
      act_q  <= act_nxt;
    end
  end

  assign sreg_o   = sreg_q;
  assign active_o = act_q;

endmodule

// File: rtl/scr_route_decode.sv
module scr_route_decode
  import scr_pkg::*;
(
  input  logic [CHAIN_W-1:0] chain_i,
  output route_e             route_o,
  output logic [N_INT-1:0]   int_hit_o
);

  logic [N_INT-1:0] hit;
  logic             is_ext;

  for (genvar g = 0; g < N_INT; g++) begin : g_hit
    assign hit[g] = (chain_i == INT_ID[g]);
  end

  assign is_ext = (chain_i == EXT_CHAIN) || (chain_i >= FIRST_FREE);

  always_comb begin
    if (|hit) begin
      route_o = ROUTE_INT;
    end else if (is_ext) begin
      route_o = ROUTE_EXT;
    end else begin
      route_o = ROUTE_BYP;
    end
  end

  assign int_hit_o = hit;

endmodule

// File: rtl/scr_tdo_path.sv
module scr_tdo_path
  import scr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byp_cap,
  input  logic             byp_shf,
  input  logic             tdi,
  input  logic             sel_active,
  input  logic             sel_bit,
  input  route_e           route,
  input  logic [N_INT-1:0] int_hit,
  input  logic [N_INT-1:0] int_ret,
  input  logic             ext_ret,
  output logic             ext_sout,
  output logic             tdo
);

  logic byp_q;
  logic byp_nxt;
  logic int_bit;
  logic tdo_src;
  logic tdo_q;

  always_comb begin
    byp_nxt = byp_q;
    if (byp_cap) begin
      byp_nxt = 1'b0;
    end else if (byp_shf) begin
      byp_nxt = tdi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
    end else begin
      byp_q <= byp_nxt;
    end
  end

  assign int_bit = |(int_hit & int_ret);

  always_comb begin
    if (sel_active) begin
      tdo_src = sel_bit;
    end else begin
      unique case (route)
        ROUTE_INT: tdo_src = int_bit;
        ROUTE_EXT: tdo_src = ext_ret;
        default:   tdo_src = byp_q;
      endcase
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdo_q <= 1'b0;
    end else begin
      tdo_q <= tdo_src;
    end
  end

  assign tdo      = tdo_q;
  assign ext_sout = (!sel_active && (route == ROUTE_EXT)) ? tdi : 1'b0;

endmodule

// File: rtl/scan_chain_router.sv
module scan_chain_router
  import scr_pkg::*;
(
  input  logic               tck,
  input  logic               trst_n,
  input  logic               capture_dr,
  input  logic               shift_dr,
  input  logic               update_dr,
  input  logic               sel_instr,
  input  logic               tdi,
  input  logic [N_INT-1:0]   int_ret,
  input  logic               ext_ret,
  output logic [CHAIN_W-1:0] active_chain,
  output logic               ext_sout,
  output logic               tdo
);

  logic [CHAIN_W-1:0] sel_sreg;
  logic [CHAIN_W-1:0] held_chain;
  logic [N_INT-1:0]   dec_hit;
  route_e             dec_route;
  logic               sel_cap;
  logic               sel_shf;
  logic               sel_upd;
  logic               byp_cap;
  logic               byp_shf;

  assign sel_cap = capture_dr & sel_instr;
  assign sel_shf = shift_dr   & sel_instr;
  assign sel_upd = update_dr  & sel_instr;
  assign byp_cap = capture_dr & ~sel_instr;
  assign byp_shf = shift_dr   & ~sel_instr;

  scr_select_reg u_sel (
    .clk      (tck),
    .rst_n    (trst_n),
    .cap_en   (sel_cap),
    .shf_en   (sel_shf),
    .upd_en   (sel_upd),
    .ser_in   (tdi),
    .sreg_o   (sel_sreg),
    .active_o (held_chain)
  );

  scr_route_decode u_dec (
    .chain_i   (held_chain),
    .route_o   (dec_route),
    .int_hit_o (dec_hit)
  );

  scr_tdo_path u_path (
    .clk        (tck),
    .rst_n      (trst_n),
    .byp_cap    (byp_cap),
    .byp_shf    (byp_shf),
    .tdi        (tdi),
    .sel_active (sel_instr),
    .sel_bit    (sel_sreg[0]),
    .route      (dec_route),
    .int_hit    (dec_hit),
    .int_ret    (int_ret),
    .ext_ret    (ext_ret),
    .ext_sout   (ext_sout),
    .tdo        (tdo)
  );

  assign active_chain = held_chain;

endmodule

// File: rtl/scr_checker.sv
module scr_checker
  import scr_pkg::*;
(
  input logic               tck,
  input logic               trst_n,
  input logic               capture_dr,
  input logic               shift_dr,
  input logic               update_dr,
  input logic               sel_instr,
  input logic               tdi,
  input logic               ext_ret,
  input logic [CHAIN_W-1:0] active_chain,
  input logic               ext_sout,
  input logic [CHAIN_W-1:0] sreg,
  input logic [N_INT-1:0]   int_hit
);

  logic chk_ext;
  assign chk_ext = (active_chain == 5'd3) || active_chain[4];

  AST_LOAD_ON_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
    (update_dr && sel_instr) |=> (active_chain == $past(sreg))); // R2

  AST_HOLD_OTHERWISE: assert property (@(posedge tck) disable iff (!trst_n)
    !(update_dr && sel_instr) |=> $stable(active_chain)); // R3

  AST_EXT_FORWARD: assert property (@(posedge tck) disable iff (!trst_n)
    (chk_ext && !sel_instr) |-> (ext_sout == tdi)); // R5

  AST_EXT_QUIET: assert property (@(posedge tck) disable iff (!trst_n)
    (!chk_ext || sel_instr) |-> (ext_sout == 1'b0)); // R5

  AST_ONE_INTERNAL: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0(int_hit)); // R6

  AST_SEL_MARKER: assert property (@(posedge tck) disable iff (!trst_n)
    (capture_dr && sel_instr) |=> (sreg == 5'b10000)); // R8

  always @(negedge tck) begin
    if (trst_n === 1'b0) begin
      AST_RESET_CHAIN: assert (active_chain == 5'd3); // R4
    end
  end

endmodule

bind scan_chain_router scr_checker u_chk (
  .tck          (tck),
  .trst_n       (trst_n),
  .capture_dr   (capture_dr),
  .shift_dr     (shift_dr),
  .update_dr    (update_dr),
  .sel_instr    (sel_instr),
  .tdi          (tdi),
  .ext_ret      (ext_ret),
  .active_chain (active_chain),
  .ext_sout     (ext_sout),
  .sreg         (sel_sreg),
  .int_hit      (dec_hit)
);

// File: tb/scan_chain_router_tb.sv
`timescale 1ns/1ps
module scan_chain_router_tb_top;

  logic       tck = 1'b0;
  logic       trst_n;
  logic       capture_dr, shift_dr, update_dr, sel_instr, tdi;
  logic [5:0] int_ret;
  logic       ext_ret;
  logic [4:0] active_chain;
  logic       ext_sout;
  logic       tdo;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 tck = ~tck;

  scan_chain_router dut_i (
    .tck(tck), .trst_n(trst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .sel_instr(sel_instr), .tdi(tdi), .int_ret(int_ret),
    .ext_ret(ext_ret), .active_chain(active_chain), .ext_sout(ext_sout), .tdo(tdo)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic is_ext(input logic [4:0] n);
    return (n == 5'd3) || (n >= 5'd16);
  endfunction

  function automatic logic is_rsv(input logic [4:0] n);
    return (n >= 5'd6) && (n <= 5'd14);
  endfunction

  function automatic logic exp_tdo(input logic [4:0] n, input logic [5:0] ir,
                                   input logic er, input logic byp);
    if (is_ext(n)) return er;
    case (n)
      5'd0:  return ir[0];
      5'd1:  return ir[1];
      5'd2:  return ir[2];
      5'd4:  return ir[3];
      5'd5:  return ir[4];
      5'd15: return ir[5];
      default: return byp;
    endcase
  endfunction

  task automatic tick();
    @(posedge tck); #1;
  endtask

  task automatic at_fall();
    @(negedge tck); #1;
  endtask

  // full select sequence: capture marker, shift n LSB first, update
  task automatic select_chain(input logic [4:0] n);
    logic [4:0] marker = 5'b10000;
    sel_instr  = 1'b1;
    capture_dr = 1'b1;
    tick();
    capture_dr = 1'b0;
    shift_dr   = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tdi = n[i];
      at_fall();
      chk("R8 select shift-out", tdo, marker[i]);
      tick();
    end
    shift_dr  = 1'b0;
    update_dr = 1'b1;
    tick();
    update_dr = 1'b0;
    sel_instr = 1'b0;
    chk("R2 R1 chain loaded", active_chain, n);
  endtask

  // probe routing of chain n with random data
  task automatic probe_route(input logic [4:0] n, input int reps);
    capture_dr = 1'b1;
    tick();
    capture_dr = 1'b0;
    for (int k = 0; k < reps; k++) begin
      logic [5:0] ir = 6'($urandom);
      logic       er = 1'($urandom);
      logic       d  = 1'($urandom);
      int_ret = ir; ext_ret = er; tdi = d;
      #1;
      chk(is_ext(n) ? "R5 ext_sout forward" : "R5 ext_sout quiet",
          ext_sout, is_ext(n) ? d : 1'b0);
      at_fall();
      chk(is_ext(n) ? "R5 tdo ext" : (is_rsv(n) ? "R7 bypass capture" : "R6 tdo internal"),
          tdo, exp_tdo(n, ir, er, 1'b0));
      tick();
    end
    if (is_rsv(n)) begin
      shift_dr = 1'b1;
      tdi      = 1'b1;
      tick();
      shift_dr = 1'b0;
      tdi      = 1'b0;
      at_fall();
      chk("R7 bypass shift", tdo, 1'b1);
      tick();
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    trst_n = 1'b0; capture_dr = 1'b0; shift_dr = 1'b0; update_dr = 1'b0;
    sel_instr = 1'b0; tdi = 1'b0; int_ret = '0; ext_ret = 1'b1;
    #12;
    chk("R4 reset chain", active_chain, 5'd3);
    chk("R4 reset tdo", tdo, 1'b0);
    @(posedge tck); #1;
    trst_n = 1'b1;
    tick(); tick();
    chk("R3 idle hold", active_chain, 5'd3);

    // choose an external number, then try to disturb it
    select_chain(5'd20);
    for (int i = 0; i < 3; i++) begin
      capture_dr = 1'b1; tick(); capture_dr = 1'b0;
      shift_dr = 1'b1; tdi = 1'($urandom); tick(); shift_dr = 1'b0;
      update_dr = 1'b1; tick(); update_dr = 1'b0;
    end
    chk("R3 other instruction hold", active_chain, 5'd20);
    sel_instr = 1'b1;
    capture_dr = 1'b1; tick(); capture_dr = 1'b0;
    shift_dr = 1'b1; tdi = 1'b1; tick(); tick(); shift_dr = 1'b0;
    sel_instr = 1'b0;
    tick();
    chk("R3 select without update", active_chain, 5'd20);

    // falling-edge retiming of tdo
    ext_ret = 1'b1;
    at_fall();
    chk("R9 tdo follows at fall", tdo, 1'b1);
    tick();
    ext_ret = 1'b0;
    #0.5;
    chk("R9 tdo holds before fall", tdo, 1'b1);
    at_fall();
    chk("R9 tdo updates at fall", tdo, 1'b0);

    // select-instruction path blocks external forwarding
    sel_instr = 1'b1; tdi = 1'b1; #1;
    chk("R5 ext_sout quiet under select", ext_sout, 1'b0);
    sel_instr = 1'b0; tdi = 1'b0;
    tick();

    // sweep every number
    for (int n = 0; n < 32; n++) begin
      select_chain(5'(n));
      probe_route(5'(n), 3);
    end

    // random selections
    for (int r = 0; r < 30; r++) begin
      logic [4:0] n = 5'($urandom);
      select_chain(n);
      probe_route(n, 2);
    end

    // reset in the middle of the run
    select_chain(5'd15);
    trst_n = 1'b0;
    #1;
    chk("R4 mid-run reset chain", active_chain, 5'd3);
    chk("R4 mid-run reset tdo", tdo, 1'b0);
    @(posedge tck); #1;
    trst_n = 1'b1;
    tick();
    chk("R1 chain after reset", active_chain, 5'd3);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule